// File: doc/BRIEF.md
# Byte-Wide Programmable ROM Pin Emulator

This block stands in for a byte-wide, one-time-writable read-only memory as it looks from its pins, so that a board-level or system model can talk to it with the same control sequences a real part would need. It samples an address, an active-low combined chip-select/program-strobe, an active-low output enable, a flag telling it that the programming supply is present, and a flag telling it that the identifier voltage sits on address line 9. From these it picks one of seven operating modes and either drives a byte on a tri-state data bus (modelled as separate in, out and enable lines) or leaves the bus floating.

Storage is a small internal array indexed by the low address bits. Writes follow the one-way rule of such memories: a stored bit can go from one to zero but never back, so every write ANDs new data into the old byte. A write is committed only when the strobe rises at the end of an undisturbed pulse. The access behaviour is counted in clock cycles: a long delay after an address, strobe or supply change, a shorter one after the output enable falls, and a float delay before the bus is released.

Top module: `prom_bus_model`

## Requirements
- R1: With strobe low, output enable low, no programming supply and the identifier condition absent, the byte stored at the address index is driven and flagged valid.
- R2: With strobe low and output enable high and no programming supply, no data is flagged valid and the bus floats once the float delay has elapsed.
- R3: With the strobe high and no programming supply (standby), the bus floats and no data is valid, whether output enable is high or low.
- R4: With the programming supply present, strobe low and output enable high (program mode), no data is driven; the data input is taken in and written when the strobe rises.
- R5: After reset every stored byte reads 0xFF, and a write stores the old byte ANDed with the written byte, so bits only go from one to zero.
- R6: With the programming supply present and both strobe and output enable low (verify mode), the stored byte at the address is driven.
- R7: With the programming supply present and the strobe high (inhibit), the bus floats; a pulse that leaves program mode other than by the strobe rising into inhibit writes nothing.
- R8: Identifier mode needs the identifier flag, strobe and output enable low, no programming supply, and every address bit other than bits 0 and 9 at zero; address bit 0 low returns 0x01 and high returns 0x9B, both with odd parity and bit 7 as the parity bit. Otherwise an ordinary read takes place.
- R9: Data becomes valid after the ACC_CYC-th clock edge after the first edge that samples an address, strobe-fall, supply or identifier-flag change, and after the OE_CYC-th edge after the first edge sampling output enable low; both must have elapsed.
- R10: When the drive condition goes away, valid drops after the first edge that samples it, dq_out reads 0 whenever valid is low, and dq_oe stays high for DF_CYC more edges before it drops.
- R11: An address change while a program pulse is in progress aborts the write, and the rest of that pulse writes nothing.
- R12: Only the low MEM_AW address bits index the array; addresses differing only above them alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| ce_pgm_n | input | 1 | Active-low chip select and program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_on | input | 1 | Programming supply present |
| id_hv | input | 1 | Identifier voltage present on address line 9 |
| dq_in | input | 8 | Data bus as seen when the host drives it |
| dq_out | output | 8 | Data driven by the block, 0 when not valid |
| dq_oe | output | 1 | Tri-state enable of the data bus |
| dq_valid | output | 1 | Data on dq_out is valid |

## Verification
Every result is registered once, so a change sampled at clock edge 0 shows on the ports after edge 0; valid data is due after edge ACC_CYC (or OE_CYC for an output-enable fall), the bus release after edge DF_CYC, and a write is visible as soon as the strobe-rise edge has passed. The bench changes inputs on the falling clock edge and samples on a later falling edge, each vector carrying the number of edges to wait, and the timing vectors sample once one edge before the due edge and once at it to show the count is exact. Write effects are read back through verify or read mode after the full access delay.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUTDIS,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT
    } prom_mode_e;

    // Identifier byte: 7-bit payload with bit 7 chosen for odd parity.
    function automatic logic [7:0] id_byte(input logic [6:0] payload);
        return {~(^payload), payload};
    endfunction

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
    import prom_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    output prom_mode_e        mode,
    output logic              drive_req,
    output logic              sel_ident
);

    // Address bits 0 and 9 are free in identifier mode; all others must be low.
    localparam logic [ADDR_W-1:0] ID_FREE = ADDR_W'(1) | (ADDR_W'(1) << 9);

    logic id_qual;

    always_comb begin
        id_qual = id_hv && ((addr & ~ID_FREE) == '0);
        if (ce_n) begin
            mode = vpp_on ? MD_INHIBIT : MD_STANDBY;
        end else if (oe_n) begin
            mode = vpp_on ? MD_PROGRAM : MD_OUTDIS;
        end else if (vpp_on) begin
            mode = MD_VERIFY;
        end else if (id_qual) begin
            mode = MD_IDENT;
        end else begin
            mode = MD_READ;
        end
        drive_req = (mode == MD_READ) || (mode == MD_IDENT) || (mode == MD_VERIFY);
        sel_ident = (mode == MD_IDENT);
    end

endmodule

// File: rtl/prom_prog_ctrl.sv
module prom_prog_ctrl
    import prom_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  prom_mode_e        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              active;
        logic              aborted;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (mode == MD_PROGRAM) begin
            if (!p_q.active && !p_q.aborted) begin
                p_d.active = 1'b1;
                p_d.addr   = addr;
                p_d.data   = din;
            end else if (p_q.active) begin
                if (addr != p_q.addr) begin
                    p_d.active  = 1'b0;
                    p_d.aborted = 1'b1;
                end else begin
                    p_d.data = din;
                end
            end
        end else begin
            p_d.active  = 1'b0;
            p_d.aborted = 1'b0;
        end
    end

    // Commit only when the pulse ends by the strobe rising with supply still on.
    assign wr_en   = p_q.active && (mode == MD_INHIBIT);
    assign wr_idx  = p_q.addr[MEM_AW-1:0];
    assign wr_data = p_q.data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
    parameter int DATA_W = 8,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            // Cells can only be cleared: AND the new data into the old byte.
            mem_d[wr_idx] = mem_q[wr_idx] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/prom_bus_timing.sv
module prom_bus_timing #(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 4,
    parameter int OE_CYC  = 2,
    parameter int DF_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    input  logic              drive_req,
    input  logic [DATA_W-1:0] sel_byte,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              dq_valid
);

    localparam int CNT_MAX0 = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
    localparam int CNT_MAX  = (CNT_MAX0 > DF_CYC) ? CNT_MAX0 : DF_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 2);
    localparam logic [CNT_W-1:0] ACC_LIM = CNT_W'(ACC_CYC);
    localparam logic [CNT_W-1:0] OE_LIM  = CNT_W'(OE_CYC);
    localparam logic [CNT_W-1:0] DF_LIM  = CNT_W'(DF_CYC);

    typedef struct packed {
        logic              prev_ce_n;
        logic              prev_oe_n;
        logic              prev_vpp;
        logic              prev_idhv;
        logic [ADDR_W-1:0] prev_addr;
        logic [CNT_W-1:0]  acc_age;
        logic [CNT_W-1:0]  oe_age;
        logic [CNT_W-1:0]  float_left;
        logic              drv_on;
        logic              valid;
        logic [DATA_W-1:0] data;
    } tim_t;

    tim_t t_d, t_q;
    logic acc_restart;
    logic oe_restart;

    always_comb begin
        t_d = t_q;

        acc_restart = ce_n || t_q.prev_ce_n || (addr != t_q.prev_addr)
                      || (vpp_on != t_q.prev_vpp) || (id_hv != t_q.prev_idhv);
        oe_restart  = oe_n || t_q.prev_oe_n;

        if (acc_restart) begin
            t_d.acc_age = '0;
        end else if (t_q.acc_age < ACC_LIM) begin
            t_d.acc_age = t_q.acc_age + CNT_W'(1);
        end

        if (oe_restart) begin
            t_d.oe_age = '0;
        end else if (t_q.oe_age < OE_LIM) begin
            t_d.oe_age = t_q.oe_age + CNT_W'(1);
        end

        t_d.valid = drive_req && (t_d.acc_age >= ACC_LIM) && (t_d.oe_age >= OE_LIM);
        if (drive_req) begin
            t_d.data = sel_byte;
        end

        // Bus release: hold the enable DF_CYC edges after the drive condition ends.
        t_d.drv_on = drive_req || (t_q.float_left != '0);
        if (drive_req) begin
            t_d.float_left = DF_LIM;
        end else if (t_q.float_left != '0) begin
            t_d.float_left = t_q.float_left - CNT_W'(1);
        end

        t_d.prev_ce_n = ce_n;
        t_d.prev_oe_n = oe_n;
        t_d.prev_vpp  = vpp_on;
        t_d.prev_idhv = id_hv;
        t_d.prev_addr = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q           <= '0;
            t_q.prev_ce_n <= 1'b1;
            t_q.prev_oe_n <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assign dq_out   = t_q.valid ? t_q.data : '0;
    assign dq_oe    = t_q.drv_on;
    assign dq_valid = t_q.valid;

endmodule

// File: rtl/prom_bus_model.sv
module prom_bus_model
    import prom_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int MEM_AW      = 6,
    parameter int ACC_CYC     = 4,
    parameter int OE_CYC      = 2,
    parameter int DF_CYC      = 1,
    parameter logic [6:0] MFG_PAYLOAD = 7'h01,
    parameter logic [6:0] DEV_PAYLOAD = 7'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_pgm_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              dq_valid
);

    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] MFG_BYTE = id_byte(MFG_PAYLOAD);
    localparam logic [DATA_W-1:0] DEV_BYTE = id_byte(DEV_PAYLOAD);

    prom_mode_e        mode_w;
    logic              drive_w;
    logic              ident_w;
    logic              wr_en_w;
    logic [MEM_AW-1:0] wr_idx_w;
    logic [DATA_W-1:0] wr_data_w;
    logic [DATA_W-1:0] rd_data_w;
    logic [DATA_W-1:0] sel_byte_w;

    prom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (addr),
        .ce_n      (ce_pgm_n),
        .oe_n      (oe_n),
        .vpp_on    (vpp_on),
        .id_hv     (id_hv),
        .mode      (mode_w),
        .drive_req (drive_w),
        .sel_ident (ident_w)
    );

    prom_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_w),
        .addr    (addr),
        .din     (dq_in),
        .wr_en   (wr_en_w),
        .wr_idx  (wr_idx_w),
        .wr_data (wr_data_w)
    );

    prom_cell_array #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (addr[MEM_AW-1:0]),
        .rd_data (rd_data_w),
        .wr_en   (wr_en_w),
        .wr_idx  (wr_idx_w),
        .wr_data (wr_data_w)
    );

    always_comb begin
        if (ident_w) begin
            sel_byte_w = addr[0] ? DEV_BYTE : MFG_BYTE;
        end else begin
            sel_byte_w = rd_data_w;
        end
    end

    prom_bus_timing #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ACC_CYC(ACC_CYC),
        .OE_CYC (OE_CYC),
        .DF_CYC (DF_CYC)
    ) u_tim (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .ce_n      (ce_pgm_n),
        .oe_n      (oe_n),
        .vpp_on    (vpp_on),
        .id_hv     (id_hv),
        .drive_req (drive_w),
        .sel_byte  (sel_byte_w),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .dq_valid  (dq_valid)
    );

endmodule

// File: rtl/prom_bus_model_chk.sv
module prom_bus_model_chk
    import prom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic [7:0] dq_out,
    input logic       dq_oe,
    input logic       dq_valid,
    input prom_mode_e mode,
    input logic       sel_ident,
    input logic       wr_en
);

    // R1: valid data only follows a sample with strobe and output enable low
    p_valid_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> (!$past(ce_n) && !$past(oe_n)));

    // R3: a standby sample never yields valid data
    p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dq_valid);

    // R4: program mode never yields valid data
    p_program_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == MD_PROGRAM) |-> !dq_valid);

    // R4: a write happens only at the strobe rise that ends a program pulse
    p_write_at_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((mode == MD_INHIBIT) && $past(mode == MD_PROGRAM)));

    // R8: identifier bytes carry odd parity
    p_id_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && $past(sel_ident)) |-> (^dq_out == 1'b1));

    // R10: valid data implies the bus is driven
    p_valid_while_driven_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dq_oe);

endmodule

bind prom_bus_model prom_bus_model_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_pgm_n),
    .oe_n      (oe_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dq_valid  (dq_valid),
    .mode      (mode_w),
    .sel_ident (ident_w),
    .wr_en     (wr_en_w)
);

// File: tb/tb_prom_bus_model.sv
module tb_prom_bus_model;

    localparam int ADDR_W  = 19;
    localparam int ACC_CYC = 4;
    localparam int NVEC    = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_pgm_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              vpp_on = 1'b0;
    logic              id_hv = 1'b0;
    logic [7:0]        dq_in = '0;
    logic [7:0]        dq_out;
    logic              dq_oe;
    logic              dq_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    prom_bus_model dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ce_pgm_n (ce_pgm_n),
        .oe_n     (oe_n),
        .vpp_on   (vpp_on),
        .id_hv    (id_hv),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .dq_valid (dq_valid)
    );

    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              vpp;
        logic              idhv;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        din;
        logic [3:0]        waitn;
        logic              e_oe;
        logic              e_valid;
        logic [7:0]        e_out;
        logic [3:0]        req;
    } vec_t;

    // ce, oe, vpp, idhv, addr, din, edges to wait, exp oe, exp valid, exp data, requirement
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b0,1'b0,1'b0,19'h00005,8'h00,4'd6,1'b0,1'b0,8'h00,4'd3},  // R3 standby
        '{1'b0,1'b0,1'b0,1'b0,19'h00005,8'h00,4'd4,1'b1,1'b0,8'h00,4'd9},  // R9 one edge early
        '{1'b0,1'b0,1'b0,1'b0,19'h00005,8'h00,4'd1,1'b1,1'b1,8'hFF,4'd1},  // R1 R5 erased byte
        '{1'b0,1'b1,1'b1,1'b0,19'h00005,8'hA5,4'd1,1'b1,1'b0,8'h00,4'd10}, // R10 float hold
        '{1'b0,1'b1,1'b1,1'b0,19'h00005,8'hA5,4'd1,1'b0,1'b0,8'h00,4'd4},  // R4 program quiet
        '{1'b1,1'b1,1'b1,1'b0,19'h00005,8'hA5,4'd2,1'b0,1'b0,8'h00,4'd7},  // R7 inhibit floats
        '{1'b0,1'b0,1'b1,1'b0,19'h00005,8'hA5,4'd5,1'b1,1'b1,8'hA5,4'd6},  // R6 verify
        '{1'b0,1'b1,1'b1,1'b0,19'h00005,8'h3C,4'd3,1'b0,1'b0,8'h00,4'd4},  // R4 second pulse
        '{1'b1,1'b1,1'b1,1'b0,19'h00005,8'h3C,4'd1,1'b0,1'b0,8'h00,4'd7},  // R7 commit edge
        '{1'b0,1'b0,1'b1,1'b0,19'h00005,8'h3C,4'd5,1'b1,1'b1,8'h24,4'd5},  // R5 AND rule
        '{1'b0,1'b0,1'b0,1'b0,19'h00005,8'h00,4'd5,1'b1,1'b1,8'h24,4'd1},  // R1 read back
        '{1'b0,1'b0,1'b0,1'b1,19'h00000,8'h00,4'd5,1'b1,1'b1,8'h01,4'd8},  // R8 maker code
        '{1'b0,1'b0,1'b0,1'b1,19'h00001,8'h00,4'd5,1'b1,1'b1,8'h9B,4'd8},  // R8 device code
        '{1'b0,1'b0,1'b0,1'b1,19'h00201,8'h00,4'd5,1'b1,1'b1,8'h9B,4'd8},  // R8 bit 9 free
        '{1'b0,1'b0,1'b0,1'b1,19'h00002,8'h00,4'd5,1'b1,1'b1,8'hFF,4'd8},  // R8 not qualified
        '{1'b0,1'b1,1'b0,1'b0,19'h00002,8'h00,4'd6,1'b0,1'b0,8'h00,4'd2},  // R2 output disable
        '{1'b0,1'b0,1'b0,1'b0,19'h00002,8'h00,4'd2,1'b1,1'b0,8'h00,4'd9},  // R9 oe delay early
        '{1'b0,1'b0,1'b0,1'b0,19'h00002,8'h00,4'd1,1'b1,1'b1,8'hFF,4'd9},  // R9 oe delay due
        '{1'b1,1'b0,1'b0,1'b0,19'h00002,8'h00,4'd2,1'b0,1'b0,8'h00,4'd3}   // R3 oe low ignored
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic c, input logic o, input logic v, input logic h,
                         input logic [ADDR_W-1:0] a, input logic [7:0] d);
        ce_pgm_n = c;
        oe_n     = o;
        vpp_on   = v;
        id_hv    = h;
        addr     = a;
        dq_in    = d;
    endtask

    task automatic check(input string tag, input logic e_oe, input logic e_valid,
                         input logic [7:0] e_out);
        n_checks++;
        if (dq_oe !== e_oe || dq_valid !== e_valid || dq_out !== e_out) begin
            n_fail++;
            $display("FAIL %s: got oe=%b valid=%b data=%02h, expected oe=%b valid=%b data=%02h",
                     tag, dq_oe, dq_valid, dq_out, e_oe, e_valid, e_out);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        check("R10 reset state", 1'b0, 1'b0, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].ce_n, VECS[i].oe_n, VECS[i].vpp, VECS[i].idhv,
                  VECS[i].addr, VECS[i].din);
            tick(int'(VECS[i].waitn));
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].e_oe, VECS[i].e_valid, VECS[i].e_out);
        end

        // R11: address change mid-pulse aborts the write
        apply(1'b0, 1'b1, 1'b1, 1'b0, 19'h00007, 8'h00); tick(2);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 19'h00008, 8'h00); tick(2);
        apply(1'b1, 1'b1, 1'b1, 1'b0, 19'h00008, 8'h00); tick(2);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 19'h00007, 8'h00); tick(ACC_CYC + 1);
        check("R11 first address kept", 1'b1, 1'b1, 8'hFF);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 19'h00008, 8'h00); tick(ACC_CYC + 1);
        check("R11 second address kept", 1'b1, 1'b1, 8'hFF);

        // R7: pulse ended by supply removal writes nothing
        apply(1'b0, 1'b1, 1'b1, 1'b0, 19'h00009, 8'h00); tick(2);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 19'h00009, 8'h00); tick(2);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 19'h00009, 8'h00); tick(2);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 19'h00009, 8'h00); tick(ACC_CYC + 1);
        check("R7 no write without inhibit end", 1'b1, 1'b1, 8'hFF);

        // R12: upper address bits alias onto the array
        apply(1'b0, 1'b1, 1'b1, 1'b0, 19'h00043, 8'h0F); tick(2);
        apply(1'b1, 1'b1, 1'b1, 1'b0, 19'h00043, 8'h0F); tick(2);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 19'h00003, 8'h00); tick(ACC_CYC + 1);
        check("R12 alias read", 1'b1, 1'b1, 8'h0F);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule